// File: doc/BRIEF.md
# Byte-Wide SPI Shift Peripheral

This block is a register-driven SPI master with one 8-bit shift register shared between two slave devices. Each slave has its own active-low chip-select. A host reaches it through two 16-bit registers. The data register (address 0) holds the byte to send and, after a read, the byte received. The control/status register (address 1) holds the slave selects, the direction, the start request and two read-only status flags.

A byte transfer uses a four-phase handshake:

1. The host stores the byte and raises the start request.
2. The block captures the byte and raises `loaded`.
3. The host withdraws the request.
4. The block raises `done` once all eight bits have moved.

Frames longer than a byte are sent by the host as consecutive bytes, most significant byte first.

The serial side runs in SPI mode 0. SCLK idles low. MOSI changes after each falling edge, and MISO is sampled on each rising edge, most significant bit first. SCLK is divided down from the system clock by a parameter.

Top module: `sbm_top`

## Requirements
- R1: After reset both registers read 0, both `cs_n` outputs are high and `sclk` is low.
- R2: Control bit 0 drives `cs_n[0]` low and control bit 1 drives `cs_n[1]` low, for as long as each bit is set. Writing 0 to the control register releases both selects.
- R3: With control bit 2 clear (write), the low byte of the data register goes out on `mosi`, MSB first. `mosi` is stable at every rising `sclk` edge.
- R4: With control bit 2 set (read), `mosi` stays low and eight `miso` bits are sampled MSB first on rising `sclk` edges. Once done is set, the data register reads the received byte in bits 7:0 and zero in bits 15:8.
- R5: Setting control bit 4 (start) while the block is idle and `loaded` is clear captures the data register and sets read-only control bit 5 (`loaded`).
- R6: `loaded` clears only after start has been written low. While start stays high after `loaded`, no second transfer begins: each transfer gives exactly 8 rising `sclk` edges.
- R7: Read-only control bit 3 (`done`) rises only when all 8 bits have shifted and start has been withdrawn. It clears when the next request is accepted, and it is never set together with `loaded`.
- R8: `sclk` is low whenever no transfer is active. Its period during a transfer is 2*HALF_DIV system clocks.
- R9: Control bits 0, 1, 2 and 4 read back as written. Writes to bits 3 and 5 have no effect, and bits 15:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 data, 1 control/status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip-selects, bit 0 codec slave, bit 1 touch slave |

## Verification
The hardest case to reach is a host that keeps the start request high after `loaded` appears. In that case the block must finish the byte but neither report done nor start a second byte. The bench holds start for many SCLK periods and counts rising edges with a slave model. It checks that done stays low, then drops start and confirms that done follows with no extra edges. Around this, every byte value goes out on one slave and comes back on the other, with received bits compared against arithmetic patterns.

// File: rtl/sbm_pkg.sv
// Package: register addresses and control-word bit positions shared by the
// SPI byte master. The control bit positions are fixed because host
// software decodes them.
package sbm_pkg;
    localparam int REG_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLV   = 2;
    localparam int CB_SEL0   = 0;
    localparam int CB_SEL1   = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_DONE   = 3;
    localparam int CB_GO     = 4;
    localparam int CB_LOADED = 5;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/sbm_clkgen.sv
// Half-period tick generator. Assumes en is held high for the whole
// transfer. Emits one tick every HALF_DIV cycles while enabled and restarts
// from zero whenever en is low.
module sbm_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count system cycles within one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sbm_shifter.sv
// Mode-0 byte shifter. On start it loads the transmit byte (zeros in read
// mode) and produces BYTE_W SCLK pulses, one per half-period tick pair.
// It samples miso on rising edges and advances mosi on falling edges.
// finish pulses for one cycle after the last falling edge.
module sbm_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_mode,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              finish,
    output logic              rx_load
);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] tx_q, rx_q;
    logic [BW-1:0]     bit_q;
    logic              busy_q, sclk_q, mode_q, fin_q;

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign mosi    = busy_q && tx_q[BYTE_W-1];
    assign rx_byte = rx_q;
    assign finish  = fin_q;
    assign rx_load = fin_q && mode_q;

    // Transfer sequencing: load, toggle SCLK on ticks, shift data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            mode_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start && !busy_q) begin
                tx_q   <= rd_mode ? '0 : tx_byte;
                bit_q  <= '0;
                busy_q <= 1'b1;
                sclk_q <= 1'b0;
                mode_q <= rd_mode;
            end else if (busy_q && tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[BYTE_W-2:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                    if (bit_q == LAST_BIT) begin
                        busy_q <= 1'b0;
                        fin_q  <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sbm_regs.sv
// Host register file and load/loaded/done handshake. Assumes one bus
// access per cycle and combinational read data. A request is accepted only
// when the shifter is idle, loaded is clear and no earlier byte still
// awaits its done report.
module sbm_regs
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              start,
    output logic              rd_mode,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [NUM_SLV-1:0] sel,
    output logic              go,
    output logic              loaded,
    output logic              done
);
    logic [REG_W-1:0]   data_q;
    logic [NUM_SLV-1:0] sel_q;
    logic               dir_q, go_q, loaded_q, done_q, pend_q;
    logic               ctl_wr, dat_wr;

    assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign dat_wr  = bus_wr && (bus_addr == ADDR_DATA);
    assign start   = go_q && !loaded_q && !busy && !pend_q;
    assign rd_mode = dir_q;
    assign tx_byte = data_q[BYTE_W-1:0];
    assign sel     = sel_q;
    assign go      = go_q;
    assign loaded  = loaded_q;
    assign done    = done_q;

    // Writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            dir_q <= 1'b0;
            go_q  <= 1'b0;
        end else if (ctl_wr) begin
            sel_q <= bus_wdata[CB_SEL1:CB_SEL0];
            dir_q <= bus_wdata[CB_DIR];
            go_q  <= bus_wdata[CB_GO];
        end
    end

    // Data register: a received byte has priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rx_load) data_q <= {{(REG_W-BYTE_W){1'b0}}, rx_byte};
        else if (dat_wr)  data_q <= bus_wdata;
    end

    // Handshake flags: loaded on accept, done after shift and withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            done_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else if (start) begin
            loaded_q <= 1'b1;
            done_q   <= 1'b0;
            pend_q   <= 1'b1;
        end else begin
            if (loaded_q && !go_q) loaded_q <= 1'b0;
            if (pend_q && !busy && !loaded_q) begin
                done_q <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_DATA) begin
            bus_rdata = data_q;
        end else begin
            bus_rdata[CB_SEL1:CB_SEL0] = sel_q;
            bus_rdata[CB_DIR]          = dir_q;
            bus_rdata[CB_DONE]         = done_q;
            bus_rdata[CB_GO]           = go_q;
            bus_rdata[CB_LOADED]       = loaded_q;
        end
    end
endmodule

// File: rtl/sbm_top.sv
// Top of the SPI byte master: register file, half-period tick generator
// and mode-0 shifter. Chip-selects follow the select bits directly.
module sbm_top
    import sbm_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [1:0]        cs_n
);
    logic              start, rd_mode, shift_busy, tick, fin, rx_load;
    logic              go_bit, loaded_bit, done_bit;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    logic [NUM_SLV-1:0] sel;

    sbm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(shift_busy),
        .rx_load(rx_load), .rx_byte(rx_byte), .start(start),
        .rd_mode(rd_mode), .tx_byte(tx_byte), .sel(sel), .go(go_bit),
        .loaded(loaded_bit), .done(done_bit)
    );

    sbm_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(shift_busy), .tick(tick)
    );

    sbm_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
        .tx_byte(tx_byte), .tick(tick), .miso(miso), .busy(shift_busy),
        .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .finish(fin),
        .rx_load(rx_load)
    );

    // Active-low select per slave.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLV; gi++) begin : g_cs
            assign cs_n[gi] = ~sel[gi];
        end
    endgenerate
endmodule

// File: rtl/sbm_chk.sv
// Checker for the SPI byte master: handshake ordering and serial-side rules.
module sbm_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic go,
    input logic loaded,
    input logic done
);
    // R7
    loaded_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loaded && done));
    // R7
    done_after_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !go);
    // R5
    loaded_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded) |-> go);
    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    // R3
    mosi_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
endmodule

bind sbm_top sbm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .busy(shift_busy),
    .go(go_bit), .loaded(loaded_bit), .done(done_bit)
);

// File: tb/sbm_top_tb_top.sv
module sbm_top_tb_top;
    localparam int HALF = 2;

    logic clk = 0, rst_n = 0;
    logic bus_addr = 0, bus_wr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic sclk, mosi, miso;
    logic [1:0] cs_n;

    int checks = 0, fails = 0;
    int rise_cnt = 0, base_cnt = 0, cyc = 0, prev_cyc = 0, last_gap = 0;
    logic [7:0] slv_pat = 0, slv_rx = 0;
    logic [1:0] cs_at_rise = 2'b11;
    logic done_flag = 0;

    always #10 clk = ~clk;

    sbm_top #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Slave model: serve pattern MSB first, capture mosi on rising sclk.
    int idx;
    assign idx  = rise_cnt - base_cnt;
    assign miso = (idx >= 0 && idx < 8) ? slv_pat[7 - idx] : 1'b0;

    always @(posedge clk) cyc++;
    always @(posedge sclk) begin
        slv_rx     = {slv_rx[6:0], mosi};
        cs_at_rise = cs_n;
        last_gap   = cyc - prev_cyc;
        prev_cyc   = cyc;
        rise_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_bit(input int b, input logic v, input string req);
        logic [15:0] r;
        int n = 0;
        rd(1, r);
        while (r[b] !== v && n < 2000) begin
            rd(1, r);
            n++;
        end
        if (n >= 2000) chk(req, r[b], v);
    endtask

    // One full handshake on slave dev; rx returns the data register after.
    task automatic xfer(input int dev, input logic rdm, input logic [15:0] d,
                        input logic [7:0] pat, output logic [15:0] rx);
        logic [15:0] ctl;
        ctl = 16'(1 << dev) | (16'(rdm) << 2);
        wr(0, d);
        slv_pat  = pat;
        base_cnt = rise_cnt;
        wr(1, ctl | 16'h0010);
        wait_bit(5, 1'b1, "R5");
        wr(1, ctl);
        wait_bit(3, 1'b1, "R7");
        rd(0, rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] r, rx;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(1, r); chk("R1 ctrl", r, 0);
        rd(0, r); chk("R1 data", r, 0);
        chk("R1 cs_n", cs_n, 2'b11);
        chk("R1 sclk", sclk, 0);
        // R9 readback: bits 3 and 5 ignored, upper bits zero
        wr(1, 16'hFFEF); rd(1, r); chk("R9 readback", r, 16'h0007);
        chk("R2 both selected", cs_n, 2'b00);
        wr(1, 16'h0000); chk("R2 release", cs_n, 2'b11);
        rd(1, r); chk("R9 cleared", r, 0);
        repeat (10) @(negedge clk);
        chk("R8 idle sclk", sclk, 0);

        // Exhaustive byte sweep: write on slave 0, read on slave 1.
        for (int b = 0; b < 256; b++) begin
            n0 = rise_cnt;
            xfer(0, 1'b0, {~b[7:0], b[7:0]}, 8'h00, rx);
            chk("R3 mosi byte", slv_rx, b);
            chk("R2 cs during write", cs_at_rise, 2'b10);
            chk("R6 edges write", rise_cnt - n0, 8);
            chk("R8 period", last_gap, 2 * HALF);
            chk("R3 data kept", rx, {~b[7:0], b[7:0]});
            n0 = rise_cnt;
            xfer(1, 1'b1, 16'hFFFF, 8'(b ^ 8'h5A), rx);
            chk("R4 rx data", rx, {8'h00, 8'(b ^ 8'h5A)});
            chk("R4 mosi low", slv_rx, 0);
            chk("R2 cs during read", cs_at_rise, 2'b01);
            chk("R6 edges read", rise_cnt - n0, 8);
        end

        // Held request: no second byte, no done until withdrawn.
        wr(0, 16'h00C3);
        base_cnt = rise_cnt; slv_pat = 0;
        n0 = rise_cnt;
        wr(1, 16'h0011);
        wait_bit(5, 1'b1, "R5");
        repeat (40 * HALF) @(negedge clk);
        rd(1, r);
        chk("R6 loaded held", r[5], 1);
        chk("R7 no done while held", r[3], 0);
        chk("R6 single byte", rise_cnt - n0, 8);
        chk("R3 held byte", slv_rx, 8'hC3);
        wr(1, 16'h0001);
        wait_bit(3, 1'b1, "R7");
        rd(1, r);
        chk("R6 loaded cleared", r[5], 0);
        repeat (10 * HALF) @(negedge clk);
        chk("R6 still one byte", rise_cnt - n0, 8);
        // R7 done clears on next accept
        wr(1, 16'h0011);
        wait_bit(5, 1'b1, "R5");
        rd(1, r);
        chk("R7 done cleared", r[3], 0);
        wr(1, 16'h0001);
        wait_bit(3, 1'b1, "R7");
        wr(1, 16'h0000);
        chk("R2 final release", cs_n, 2'b11);
        repeat (4) @(negedge clk);
        chk("R8 sclk idle end", sclk, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule